// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Mapper

This block sits between a console CPU bus, a video bus and the memories on a cartridge. Eight small control registers sit in a window of the CPU address space. The CPU writes them to choose which pages of the memories appear where. On every cycle the block turns the current CPU address into an address and a chip enable for one of three targets: the program flash (512 kB, 16 kB pages), the work RAM (32 kB, 8 kB pages) or an expansion port. It also turns the current video address into an address and an enable for the character RAM or for the console's own nametable RAM.

Program space has four layouts. The paged half can sit low with the high half fixed to the last page, or it can sit high with the low half fixed to page 0. Both halves can be paged on their own, or one 32 kB page can cover the whole space. In the character RAM, one 1 kB slot of the 8 kB pattern space is banked and every other slot maps straight through. Nametable mirroring has four settings. When the expansion option is built in, the top four bytes of the register window pass through to an external port.

All outputs are registered. An address presented before a clock edge shows its translation after that edge.

Top module: `cart_bank_mapper`

## Requirements
- R1: Synchronous reset clears all registers. After reset the CPU side acts as program layout 0 with bank 0, work-RAM page 0 and vertical mirroring, and the video side uses character page 0 with switchable slot 0.
- R2: A register is written when `cpu_we` is high, `cpu_addr[15:6]` equals the window base $5000 and `cpu_addr[2:0]` is 0. The register index is `cpu_addr[5:3]` and the value is `cpu_wdata[3:0]`. Writes to any other address, such as $5001, $5009 or $5040, change nothing.
- R3: Layout 0 is selected by register 0, bits 1:0 = 0. In this layout $8000-$BFFF shows bank A and $C000-$FFFF shows page 31. `prg_addr` = {page, `cpu_addr[13:0]`}.
- R4: In layout 1, $8000-$BFFF shows page 0 and $C000-$FFFF shows bank A.
- R5: In layout 2, $8000-$BFFF shows bank A and $C000-$FFFF shows bank B.
- R6: In layout 3, the 32 kB page is bank A bits 4:1. The page number is {bankA[4:1], `cpu_addr[14]`}.
- R7: Bank A is {reg2[0], reg1[3:0]} and bank B is {reg4[0], reg3[3:0]}. Bits 3:1 of reg2 and reg4 are ignored.
- R8: CPU addresses $6000-$7FFF assert `wram_ce`. `wram_addr` = {reg5[1:0], `cpu_addr[12:0]`}, and reg5 bit 2 is ignored.
- R9: Video addresses $0000-$1FFF assert `chr_ce`. The slot `ppu_addr[12:10]` that equals the switchable slot (reg7[2:0]) uses page {reg5[3], reg6[3:0]}. Every other slot uses page equal to its slot number. `chr_addr` = {page, `ppu_addr[9:0]`}.
- R10: Video addresses $2000-$3FFF assert `nt_ce`. Register 0 bits 3:2 choose `nt_a10`: 0 vertical (`ppu_addr[10]`), 1 horizontal (`ppu_addr[11]`), 2 always 0, 3 always 1.
- R11: With the expansion option on, CPU addresses $5038-$503B assert `exp_ce`. `exp_idx` = `cpu_addr[1:0]` and `exp_we` follows the write strobe. Writes there do not load register 7, so the switchable slot stays 0.
- R12: Each output reflects the inputs sampled at the previous clock edge. Register writes take effect for accesses at the next edge. At most one CPU-side enable and at most one video-side enable is high, and addresses such as $4000 and $5000 assert no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 4 | Low nibble of the CPU data bus |
| cpu_we | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | Video address |
| prg_addr | output | 19 | Program flash address |
| prg_ce | output | 1 | Program flash enable |
| wram_addr | output | 15 | Work-RAM address |
| wram_ce | output | 1 | Work-RAM enable |
| chr_addr | output | 15 | Character-RAM address |
| chr_ce | output | 1 | Character-RAM enable |
| nt_a10 | output | 1 | Nametable RAM A10 select |
| nt_ce | output | 1 | Nametable RAM enable |
| exp_ce | output | 1 | Expansion port enable |
| exp_we | output | 1 | Expansion port write |
| exp_idx | output | 2 | Expansion port number |

## Verification
A wrong register value has no output of its own. It shows up only when an access uses that register. A corrupt bank shows as the wrong upper bits of `prg_addr` one cycle after a CPU fetch in the affected half. A bad mirror field shows as a wrong `nt_a10` on the next nametable access. A stray write from a near-miss address stays hidden until a later fetch reads the register it hit. For that reason every write check is followed at once by a probe of the dependent region. Each probe samples one edge after it is driven.

// File: rtl/cartmap_pkg.sv
package cartmap_pkg;
  typedef enum logic [1:0] {
    PM_LO_PAGED = 2'd0,
    PM_HI_PAGED = 2'd1,
    PM_BOTH     = 2'd2,
    PM_WIDE     = 2'd3
  } prg_mode_e;

  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_ONE0 = 2'd2,
    MIR_ONE1 = 2'd3
  } mirror_e;
endpackage

// File: rtl/cartmap_regfile.sv
module cartmap_regfile
  import cartmap_pkg::*;
#(
  parameter logic [15:0] BASE   = 16'h5000,
  parameter int          NREG   = 8,
  parameter int          RW     = 4,
  parameter int          PB_W   = 5,
  parameter int          WP_W   = 2,
  parameter int          CP_W   = 5,
  parameter int          SLOT_W = 3,
  parameter bit          EXP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [RW-1:0]     cpu_wdata,
  input  logic              cpu_we,
  output prg_mode_e         mode,
  output mirror_e           mir,
  output logic [PB_W-1:0]   bank_a,
  output logic [PB_W-1:0]   bank_b,
  output logic [WP_W-1:0]   wram_pg,
  output logic [CP_W-1:0]   chr_pg,
  output logic [SLOT_W-1:0] slot
);
  localparam int IDX_W = $clog2(NREG);
  localparam int TOP_W = 16 - IDX_W - 3;
  localparam int HI_W  = PB_W - RW;

  logic [NREG-1:0][RW-1:0] regs;
  logic                    hit;
  logic [IDX_W-1:0]        idx;

  assign hit = cpu_we && (cpu_addr[15:IDX_W+3] == BASE[15:IDX_W+3]) && (cpu_addr[2:0] == 3'd0);
  assign idx = cpu_addr[IDX_W+2:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (hit && (idx == IDX_W'(i)) && !(EXP_EN && (i == NREG - 1)))
          regs[i] <= cpu_wdata;
      end
    end
  end

  assign mode    = prg_mode_e'(regs[0][1:0]);
  assign mir     = mirror_e'(regs[0][3:2]);
  assign bank_a  = {regs[2][HI_W-1:0], regs[1]};
  assign bank_b  = {regs[4][HI_W-1:0], regs[3]};
  assign wram_pg = regs[5][WP_W-1:0];
  assign chr_pg  = {regs[5][RW-1], regs[6]};
  assign slot    = regs[NREG-1][SLOT_W-1:0];

  // R2: without a decoded write the register state is unchanged
  p_no_stray_write_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(regs))
    else $error("register changed without a decoded write");

  // R1: one cycle after reset every register reads zero
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (regs == '0))
    else $error("registers not cleared by reset");
endmodule

// File: rtl/cartmap_cpu_map.sv
module cartmap_cpu_map
  import cartmap_pkg::*;
#(
  parameter logic [15:0] BASE    = 16'h5000,
  parameter int          NREG    = 8,
  parameter int          PB_W    = 5,
  parameter int          POFF_W  = 14,
  parameter int          WP_W    = 2,
  parameter int          WOFF_W  = 13,
  parameter bit          EXP_EN  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            cpu_addr,
  input  logic                   cpu_we,
  input  prg_mode_e              mode,
  input  logic [PB_W-1:0]        bank_a,
  input  logic [PB_W-1:0]        bank_b,
  input  logic [WP_W-1:0]        wram_pg,
  output logic [PB_W+POFF_W-1:0] prg_addr,
  output logic                   prg_ce,
  output logic [WP_W+WOFF_W-1:0] wram_addr,
  output logic                   wram_ce,
  output logic                   exp_ce,
  output logic                   exp_we,
  output logic [1:0]             exp_idx
);
  localparam logic [15:0] EXP_BASE = BASE + 16'(8 * (NREG - 1));

  logic            half;
  logic [PB_W-1:0] page;
  logic            prg_hit, wram_hit, exp_hit;

  assign half     = cpu_addr[POFF_W];
  assign prg_hit  = cpu_addr[15];
  assign wram_hit = (cpu_addr[15:13] == 3'b011);
  assign exp_hit  = EXP_EN && (cpu_addr[15:2] == EXP_BASE[15:2]);

  always_comb begin
    unique case (mode)
      PM_LO_PAGED: page = half ? {PB_W{1'b1}} : bank_a;
      PM_HI_PAGED: page = half ? bank_a : {PB_W{1'b0}};
      PM_BOTH:     page = half ? bank_b : bank_a;
      default:     page = {bank_a[PB_W-1:1], half};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr  <= '0;
      prg_ce    <= 1'b0;
      wram_addr <= '0;
      wram_ce   <= 1'b0;
      exp_ce    <= 1'b0;
      exp_we    <= 1'b0;
      exp_idx   <= 2'd0;
    end else begin
      prg_addr  <= {page, cpu_addr[POFF_W-1:0]};
      prg_ce    <= prg_hit;
      wram_addr <= {wram_pg, cpu_addr[WOFF_W-1:0]};
      wram_ce   <= wram_hit;
      exp_ce    <= exp_hit;
      exp_we    <= exp_hit && cpu_we;
      exp_idx   <= cpu_addr[1:0];
    end
  end

  // R12: CPU-side enables are mutually exclusive
  p_cpu_ce_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prg_ce, wram_ce, exp_ce}))
    else $error("more than one CPU-side enable");

  // R3: high half in layout 0 lands on the last page
  p_last_page_r3: assert property (@(posedge clk) disable iff (rst)
    (prg_hit && half && mode == PM_LO_PAGED) |=> (prg_ce && prg_addr[PB_W+POFF_W-1:POFF_W] == {PB_W{1'b1}}))
    else $error("layout 0 high half not on last page");

  // R4: low half in layout 1 lands on page 0
  p_first_page_r4: assert property (@(posedge clk) disable iff (rst)
    (prg_hit && !half && mode == PM_HI_PAGED) |=> (prg_addr[PB_W+POFF_W-1:POFF_W] == '0))
    else $error("layout 1 low half not on page 0");

  // R11: an expansion write strobe only appears with its enable
  p_exp_we_r11: assert property (@(posedge clk) disable iff (rst)
    exp_we |-> exp_ce)
    else $error("expansion write without enable");
endmodule

// File: rtl/cartmap_vid_map.sv
module cartmap_vid_map
  import cartmap_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int CP_W   = 5,
  parameter int SLOT_W = 3,
  parameter int SOFF_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [VA_W-1:0]        ppu_addr,
  input  mirror_e                mir,
  input  logic [CP_W-1:0]        chr_pg,
  input  logic [SLOT_W-1:0]      slot,
  output logic [CP_W+SOFF_W-1:0] chr_addr,
  output logic                   chr_ce,
  output logic                   nt_a10,
  output logic                   nt_ce
);
  logic [SLOT_W-1:0] cur_slot;
  logic [CP_W-1:0]   page;
  logic              nt_hit;
  logic              a10_next;

  assign cur_slot = ppu_addr[SOFF_W+SLOT_W-1:SOFF_W];
  assign nt_hit   = ppu_addr[VA_W-1];
  assign page     = (cur_slot == slot) ? chr_pg : CP_W'(cur_slot);

  always_comb begin
    unique case (mir)
      MIR_VERT: a10_next = ppu_addr[10];
      MIR_HORZ: a10_next = ppu_addr[11];
      MIR_ONE0: a10_next = 1'b0;
      default:  a10_next = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr <= '0;
      chr_ce   <= 1'b0;
      nt_a10   <= 1'b0;
      nt_ce    <= 1'b0;
    end else begin
      chr_addr <= {page, ppu_addr[SOFF_W-1:0]};
      chr_ce   <= !nt_hit;
      nt_a10   <= a10_next;
      nt_ce    <= nt_hit;
    end
  end

  // R12: video-side enables are mutually exclusive
  p_vid_ce_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chr_ce, nt_ce}))
    else $error("both video enables high");

  // R10: single-screen 1 always selects the upper nametable
  p_one1_r10: assert property (@(posedge clk) disable iff (rst)
    (nt_hit && mir == MIR_ONE1) |=> nt_a10)
    else $error("single-screen 1 gave A10 low");

  // R9: slots other than the switchable one map straight through
  p_fixed_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (!nt_hit && cur_slot != slot) |=> (chr_addr[CP_W+SOFF_W-1:SOFF_W] == CP_W'($past(cur_slot))))
    else $error("fixed slot remapped");
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cartmap_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'h5000,
  parameter int          NREG        = 8,
  parameter int          REG_W       = 4,
  parameter int          PRG_BANK_W  = 5,
  parameter int          WRAM_BANK_W = 2,
  parameter int          CHR_BANK_W  = 5,
  parameter int          SLOT_W      = 3,
  parameter int          VA_W        = 14,
  parameter bit          EXP_EN      = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cpu_addr,
  input  logic [3:0]  cpu_wdata,
  input  logic        cpu_we,
  input  logic [13:0] ppu_addr,
  output logic [18:0] prg_addr,
  output logic        prg_ce,
  output logic [14:0] wram_addr,
  output logic        wram_ce,
  output logic [14:0] chr_addr,
  output logic        chr_ce,
  output logic        nt_a10,
  output logic        nt_ce,
  output logic        exp_ce,
  output logic        exp_we,
  output logic [1:0]  exp_idx
);
  localparam int PRG_OFF_W  = 14;
  localparam int WRAM_OFF_W = 13;
  localparam int CHR_OFF_W  = 10;

  prg_mode_e              mode;
  mirror_e                mir;
  logic [PRG_BANK_W-1:0]  bank_a, bank_b;
  logic [WRAM_BANK_W-1:0] wram_pg;
  logic [CHR_BANK_W-1:0]  chr_pg;
  logic [SLOT_W-1:0]      slot;

  cartmap_regfile #(
    .BASE(BASE_ADDR), .NREG(NREG), .RW(REG_W), .PB_W(PRG_BANK_W),
    .WP_W(WRAM_BANK_W), .CP_W(CHR_BANK_W), .SLOT_W(SLOT_W), .EXP_EN(EXP_EN)
  ) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .mode(mode), .mir(mir), .bank_a(bank_a), .bank_b(bank_b),
    .wram_pg(wram_pg), .chr_pg(chr_pg), .slot(slot)
  );

  cartmap_cpu_map #(
    .BASE(BASE_ADDR), .NREG(NREG), .PB_W(PRG_BANK_W), .POFF_W(PRG_OFF_W),
    .WP_W(WRAM_BANK_W), .WOFF_W(WRAM_OFF_W), .EXP_EN(EXP_EN)
  ) u_cpu (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .mode(mode), .bank_a(bank_a), .bank_b(bank_b), .wram_pg(wram_pg),
    .prg_addr(prg_addr), .prg_ce(prg_ce), .wram_addr(wram_addr), .wram_ce(wram_ce),
    .exp_ce(exp_ce), .exp_we(exp_we), .exp_idx(exp_idx)
  );

  cartmap_vid_map #(
    .VA_W(VA_W), .CP_W(CHR_BANK_W), .SLOT_W(SLOT_W), .SOFF_W(CHR_OFF_W)
  ) u_vid (
    .clk(clk), .rst(rst), .ppu_addr(ppu_addr), .mir(mir), .chr_pg(chr_pg), .slot(slot),
    .chr_addr(chr_addr), .chr_ce(chr_ce), .nt_a10(nt_a10), .nt_ce(nt_ce)
  );
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [3:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [18:0] prg_addr;
  logic        prg_ce;
  logic [14:0] wram_addr;
  logic        wram_ce;
  logic [14:0] chr_addr;
  logic        chr_ce;
  logic        nt_a10;
  logic        nt_ce;
  logic        exp_ce;
  logic        exp_we;
  logic [1:0]  exp_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cart_bank_mapper dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .prg_ce(prg_ce), .wram_addr(wram_addr),
    .wram_ce(wram_ce), .chr_addr(chr_addr), .chr_ce(chr_ce), .nt_a10(nt_a10), .nt_ce(nt_ce),
    .exp_ce(exp_ce), .exp_we(exp_we), .exp_idx(exp_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [13:0] v);
    @(negedge clk);
    cpu_addr = a; ppu_addr = v; cpu_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ce during reset", {31'd0, prg_ce}, 32'd0);
    @(negedge clk); rst = 1'b0;
    probe(16'hC000, 14'h2400);
    chk("R1 high half last page", prg_addr, 32'h7C000);
    chk("R1 vertical mirror", nt_a10, 1'b1);
    probe(16'h8123, 14'h0C00);
    chk("R1 bank 0", prg_addr, 32'h00123);
    chk("R1 chr identity", chr_addr, 32'h0C00);
    probe(16'h6000, 14'h0123);
    chk("R1 wram page 0", wram_addr, 32'h0000);
    chk("R1 chr page 0", chr_addr, 32'h0123);
  endtask

  task automatic t_decode;
    wr(16'h5001, 4'h5);
    wr(16'h5009, 4'h3);
    wr(16'h5040, 4'h7);
    probe(16'h8000, 14'h0);
    chk("R2 near-miss writes ignored", prg_addr, 32'h00000);
    wr(16'h5008, 4'h5);
    probe(16'h8000, 14'h0);
    chk("R2 decoded write / R12 next access", prg_addr, 32'h14000);
  endtask

  task automatic t_bank_width;
    wr(16'h5010, 4'hF);
    probe(16'h8000, 14'h0);
    chk("R7 bank bit4 set", prg_addr, 32'h54000);
    wr(16'h5010, 4'hE);
    probe(16'h8000, 14'h0);
    chk("R7 upper bits ignored", prg_addr, 32'h14000);
    wr(16'h5010, 4'h1);
    wr(16'h5018, 4'h9);
    wr(16'h5020, 4'h0);
  endtask

  task automatic t_modes;
    wr(16'h5000, 4'h0);
    probe(16'h8ABC, 14'h0); chk("R3 low half bank A", prg_addr, 32'h54ABC);
    probe(16'hC123, 14'h0); chk("R3 high half last", prg_addr, 32'h7C123);
    wr(16'h5000, 4'h1);
    probe(16'h8ABC, 14'h0); chk("R4 low half page 0", prg_addr, 32'h00ABC);
    probe(16'hC123, 14'h0); chk("R4 high half bank A", prg_addr, 32'h54123);
    wr(16'h5000, 4'h2);
    probe(16'h8ABC, 14'h0); chk("R5 low half bank A", prg_addr, 32'h54ABC);
    probe(16'hC123, 14'h0); chk("R5 high half bank B", prg_addr, 32'h24123);
    wr(16'h5000, 4'h3);
    probe(16'h8ABC, 14'h0); chk("R6 wide low", prg_addr, 32'h50ABC);
    probe(16'hC123, 14'h0); chk("R6 wide high", prg_addr, 32'h54123);
    chk("R12 prg ce", {wram_ce, prg_ce}, 32'd1);
    wr(16'h5000, 4'h0);
  endtask

  task automatic t_wram;
    wr(16'h5028, 4'h7);
    probe(16'h7FFF, 14'h0);
    chk("R8 wram page 3", wram_addr, 32'h7FFF);
    chk("R8 wram ce only", {prg_ce, wram_ce, exp_ce}, 32'b010);
    wr(16'h5028, 4'h6);
    probe(16'h6001, 14'h0);
    chk("R8 wram page 2", wram_addr, 32'h4001);
  endtask

  task automatic t_chr;
    wr(16'h5030, 4'hA);
    wr(16'h5028, 4'h8);
    probe(16'h0000, 14'h0123);
    chk("R9 banked slot", chr_addr, 32'h6923);
    chk("R9 chr ce", {nt_ce, chr_ce}, 32'b01);
    probe(16'h0000, 14'h0523);
    chk("R9 slot 1 identity", chr_addr, 32'h0523);
    probe(16'h0000, 14'h1FFF);
    chk("R9 slot 7 identity", chr_addr, 32'h1FFF);
  endtask

  task automatic t_mirror;
    wr(16'h5000, 4'h0);
    probe(16'h0, 14'h2400); chk("R10 vert 2400", nt_a10, 1'b1);
    probe(16'h0, 14'h2800); chk("R10 vert 2800", nt_a10, 1'b0);
    wr(16'h5000, 4'h4);
    probe(16'h0, 14'h2400); chk("R10 horz 2400", nt_a10, 1'b0);
    probe(16'h0, 14'h2800); chk("R10 horz 2800", nt_a10, 1'b1);
    wr(16'h5000, 4'h8);
    probe(16'h0, 14'h2C00); chk("R10 single0", nt_a10, 1'b0);
    wr(16'h5000, 4'hC);
    probe(16'h0, 14'h2000); chk("R10 single1", nt_a10, 1'b1);
    chk("R10 nt ce", {nt_ce, chr_ce}, 32'b10);
    wr(16'h5000, 4'h0);
  endtask

  task automatic t_expansion;
    @(negedge clk);
    cpu_addr = 16'h503A; cpu_wdata = 4'h3; cpu_we = 1'b1;
    @(negedge clk);
    chk("R11 write enables", {exp_ce, exp_we}, 32'b11);
    chk("R11 port 2", exp_idx, 32'd2);
    cpu_we = 1'b0;
    probe(16'h503B, 14'h0);
    chk("R11 read port 3", {exp_ce, exp_we, exp_idx}, 32'b1011);
    wr(16'h5038, 4'h5);
    probe(16'h0, 14'h1523);
    chk("R11 slot select unchanged", chr_addr, 32'h1523);
    probe(16'h0, 14'h0123);
    chk("R11 slot 0 still banked", chr_addr, 32'h6923);
  endtask

  task automatic t_unmapped;
    probe(16'h4000, 14'h0);
    chk("R12 no enable at 4000", {prg_ce, wram_ce, exp_ce}, 32'd0);
    probe(16'h5000, 14'h0);
    chk("R12 no enable at 5000", {prg_ce, wram_ce, exp_ce}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_decode();
    t_bank_width();
    t_modes();
    t_wram();
    t_chr();
    t_mirror();
    t_expansion();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule